// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block is the command front end of a small NOR-style flash model. The storage is a register array, 256 words of 32 bits by default. The block watches single-cycle host write strobes and matches them against multi-write unlock sequences. From those sequences it decodes:

- word program
- chip erase
- identification (autoselect) reads
- a fast-program bypass mode
- a command-level reset

While an embedded program or erase runs, the `ready` output is held low for a fixed number of cycles. A down-counter stands in for the internal algorithm. The array is written when that window closes. Host reads are combinational. They return either the addressed array word or identification data, depending on the current mode.

The host drives `addr` and `wrData` with `wrEn` high for one cycle per bus write. Command recognition uses the low byte of `wrData`, and the full address for the unlock and command cycles. The array index is the low 8 bits of `addr`. The array has no reset value, so an erase must be issued before the array is first read.

Top module: `flash_cmd_seq`

## Requirements
- R1: In array read mode, `rdData` equals the stored word at index `addr[7:0]`, combinationally.
- R2: A program is four writes: AAh at 555h, 55h at 2AAh, A0h at 555h, then the target address and data. `ready` is low for exactly PROG_CYCLES (8) cycles, starting in the cycle after the last write. The word is updated when `ready` returns high.
- R3: A program stores the old word ANDed with the written data. It can only clear bits.
- R4: A chip erase is six writes: AAh at 555h, 55h at 2AAh, 80h at 555h, AAh at 555h, 55h at 2AAh, 10h at 555h. `ready` is low for exactly ERASE_CYCLES (64) cycles. Afterwards every word reads FFFFFFFFh.
- R5: While `ready` is low, every write is ignored, including F0h. The operation still completes on time, and no new sequence is started.
- R6: A write with low byte F0h at any address, made between the cycles of an unfinished sequence, returns the block to array read mode. This includes the program data cycle.
- R7: Any write that does not match the next expected cycle of a sequence returns the block to array read mode.
- R8: After AAh at 555h, 55h at 2AAh and 90h at 555h, the block is in autoselect mode. Reads may repeat, and the result depends on the offset `addr[5:0]` within the sector `addr[7:6]`:
  - offset 0 returns 00000001h, the manufacturer code;
  - offset 1 returns 0000007Eh, the device code;
  - offset 2 returns 1 if bit `addr[7:6]` of PROT_MASK (default 0010b) is set, and 0 otherwise.
- R9: Autoselect mode is left only by a write with low byte F0h. Other writes in this mode change neither the mode nor the array.
- R10: AAh at 555h, 55h at 2AAh, then 20h at 555h enters bypass mode. In this mode a write of A0h (address don't care), followed by an address/data write, programs with the R2 timing. The block then returns to bypass mode.
- R11: In bypass mode, a write of 90h followed by a write of 00h (addresses don't care) returns the block to array read mode.
- R12: The synchronous `rst` input aborts any operation, including a running program, without changing the array. `ready` is high and the mode is array read from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Host write strobe, one cycle per bus write |
| addr | input | ADDR_W (12) | Bus address for writes and reads |
| wrData | input | DATA_W (32) | Write data; the low byte carries command codes |
| rdData | output | DATA_W (32) | Read data: array word or identification value |
| ready | output | 1 | High when no embedded operation is running |

## Verification
The embedded assertions assume the following about the inputs:
- `rst` is synchronous.
- `wrEn`, `addr` and `wrData` are known and stable around each rising edge.
- Each bus write lasts exactly one cycle.

The stimulus meets these conditions. It changes every input only on the falling clock edge and drops `wrEn` before the next write. Program data whose low byte is F0h would be taken as a reset (R6), so the stimulus never uses such data as a program value. The stimulus also erases the array before reading it, so no assertion or check ever sees the array's unset power-up contents.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    ST_READ,
    ST_UNL1,
    ST_UNL2,
    ST_PSETUP,
    ST_ESETUP,
    ST_EUNL1,
    ST_EUNL2,
    ST_AUTO,
    ST_BYP,
    ST_BPROG,
    ST_BEXIT,
    ST_BUSY
  } cmd_state_e;

  typedef struct packed {
    logic latchWr;
    logic commitProg;
    logic commitErase;
    logic idRead;
  } strobe_t;

  localparam logic [15:0] KEY_ADDR_A = 16'h0555;
  localparam logic [15:0] KEY_ADDR_B = 16'h02AA;
  localparam logic [7:0]  KEY_A      = 8'hAA;
  localparam logic [7:0]  KEY_B      = 8'h55;
  localparam logic [7:0]  OP_PROG    = 8'hA0;
  localparam logic [7:0]  OP_IDENT   = 8'h90;
  localparam logic [7:0]  OP_ERSETUP = 8'h80;
  localparam logic [7:0]  OP_ERCHIP  = 8'h10;
  localparam logic [7:0]  OP_BYPASS  = 8'h20;
  localparam logic [7:0]  OP_BYPEXIT = 8'h00;
  localparam logic [7:0]  OP_RESET   = 8'hF0;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrByte,
  output strobe_t           strobe,
  output logic              ready
);

  localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [ADDR_W-1:0] ADR_A = KEY_ADDR_A[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] ADR_B = KEY_ADDR_B[ADDR_W-1:0];

  cmd_state_e state, nextState;
  logic [CNT_W-1:0] busyCnt;
  logic retBypass;
  logic opErase;
  logic startProg, startErase;
  logic isKeyA, isKeyB, atKeyA, isReset, busyDone;

  assign atKeyA   = (addr == ADR_A);
  assign isKeyA   = atKeyA && (wrByte == KEY_A);
  assign isKeyB   = (addr == ADR_B) && (wrByte == KEY_B);
  assign isReset  = (wrByte == OP_RESET);
  assign busyDone = (state == ST_BUSY) && (busyCnt == '0);

  always_comb begin
    nextState  = state;
    startProg  = 1'b0;
    startErase = 1'b0;
    if (state == ST_BUSY) begin
      if (busyCnt == '0) nextState = retBypass ? ST_BYP : ST_READ;
    end else if (wrEn) begin
      unique case (state)
        ST_READ:   if (isKeyA) nextState = ST_UNL1;
        ST_UNL1:   nextState = isKeyB ? ST_UNL2 : ST_READ;
        ST_UNL2: begin
          if (atKeyA && wrByte == OP_PROG)          nextState = ST_PSETUP;
          else if (atKeyA && wrByte == OP_IDENT)    nextState = ST_AUTO;
          else if (atKeyA && wrByte == OP_ERSETUP)  nextState = ST_ESETUP;
          else if (atKeyA && wrByte == OP_BYPASS)   nextState = ST_BYP;
          else                                      nextState = ST_READ;
        end
        ST_PSETUP: begin
          if (isReset) nextState = ST_READ;
          else begin
            startProg = 1'b1;
            nextState = ST_BUSY;
          end
        end
        ST_ESETUP: nextState = isKeyA ? ST_EUNL1 : ST_READ;
        ST_EUNL1:  nextState = isKeyB ? ST_EUNL2 : ST_READ;
        ST_EUNL2: begin
          if (atKeyA && wrByte == OP_ERCHIP) begin
            startErase = 1'b1;
            nextState  = ST_BUSY;
          end else begin
            nextState = ST_READ;
          end
        end
        ST_AUTO:   if (isReset) nextState = ST_READ;
        ST_BYP: begin
          if (wrByte == OP_PROG)        nextState = ST_BPROG;
          else if (wrByte == OP_IDENT)  nextState = ST_BEXIT;
        end
        ST_BPROG: begin
          startProg = 1'b1;
          nextState = ST_BUSY;
        end
        ST_BEXIT:  nextState = (wrByte == OP_BYPEXIT) ? ST_READ : ST_BYP;
        default:   nextState = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_READ;
      busyCnt   <= '0;
      retBypass <= 1'b0;
      opErase   <= 1'b0;
    end else begin
      state <= nextState;
      if (startProg) begin
        busyCnt   <= PROG_LOAD;
        opErase   <= 1'b0;
        retBypass <= (state == ST_BPROG);
      end else if (startErase) begin
        busyCnt   <= ERASE_LOAD;
        opErase   <= 1'b1;
        retBypass <= 1'b0;
      end else if (state == ST_BUSY && busyCnt != '0) begin
        busyCnt <= busyCnt - 1'b1;
      end
    end
  end

  assign strobe.latchWr     = startProg;
  assign strobe.commitProg  = busyDone && !opErase;
  assign strobe.commitErase = busyDone && opErase;
  assign strobe.idRead      = (state == ST_AUTO);
  assign ready              = (state != ST_BUSY);

  // R5: writes cannot leave the busy window early
  p_busy_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BUSY && busyCnt != '0) |=> (state == ST_BUSY));

  // R2: busy counter steps down by one each cycle
  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BUSY && busyCnt != '0) |=> (busyCnt == $past(busyCnt) - 1'b1));

  // R9: autoselect persists unless a reset byte is written
  p_auto_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_AUTO && !(wrEn && wrByte == OP_RESET)) |=> (state == ST_AUTO));

  // R12: ready is high in the cycle after a hardware reset
  p_ready_after_rst_r12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ready);

  // R4: latch, program commit and erase commit never coincide
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.latchWr, strobe.commitProg, strobe.commitErase}));

endmodule

// File: rtl/flash_cmd_array.sv
module flash_cmd_array
  import flash_cmd_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          IDX_W     = 8,
  parameter int          SECT_W    = 2,
  parameter logic [7:0]  MFR_ID    = 8'h01,
  parameter logic [7:0]  DEV_ID    = 8'h7E,
  parameter logic [(1<<SECT_W)-1:0] PROT_MASK = 4'b0010
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int OFS_W = IDX_W - SECT_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  progIdx;
  logic [DATA_W-1:0] progData;
  logic [DATA_W-1:0] idWord;
  logic [SECT_W-1:0] sect;
  logic [OFS_W-1:0]  ofs;

  always_ff @(posedge clk) begin
    if (rst) begin
      progIdx  <= '0;
      progData <= '1;
    end else if (strobe.latchWr) begin
      progIdx  <= idx;
      progData <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.commitErase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strobe.commitProg) begin
      mem[progIdx] <= mem[progIdx] & progData;
    end
  end

  assign sect = idx[IDX_W-1 -: SECT_W];
  assign ofs  = idx[OFS_W-1:0];

  always_comb begin
    idWord = '0;
    case (ofs)
      OFS_W'(0): idWord[7:0] = MFR_ID;
      OFS_W'(1): idWord[7:0] = DEV_ID;
      OFS_W'(2): idWord[0]   = PROT_MASK[sect];
      default:   idWord      = '0;
    endcase
  end

  assign rdData = strobe.idRead ? idWord : mem[idx];

  logic [DATA_W-1:0] curWord;
  logic              edgeOnes;
  assign curWord  = mem[progIdx];
  assign edgeOnes = (&mem[0]) && (&mem[DEPTH-1]);

  // R3: a committed program never raises a bit
  p_prog_and_r3: assert property (@(posedge clk) disable iff (rst)
    strobe.commitProg |=> (curWord == ($past(curWord) & $past(progData))));

  // R4: an erase commit leaves the array all ones
  p_erase_ones_r4: assert property (@(posedge clk) disable iff (rst)
    strobe.commitErase |=> edgeOnes);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 32,
  parameter int IDX_W        = 8,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              ready
);

  strobe_t strobe;

  flash_cmd_ctrl #(
    .ADDR_W      (ADDR_W),
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) uCtrl (
    .clk   (clk),
    .rst   (rst),
    .wrEn  (wrEn),
    .addr  (addr),
    .wrByte(wrData[7:0]),
    .strobe(strobe),
    .ready (ready)
  );

  flash_cmd_array #(
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) uArray (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .idx   (addr[IDX_W-1:0]),
    .wrData(wrData),
    .rdData(rdData)
  );

endmodule

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        ready;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_cmd_seq uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .ready(ready)
  );

  localparam logic [1:0] W = 2'd0, RD = 2'd1, WT = 2'd2;
  localparam int NV = 63;
  // {op, req, addr, data}
  localparam logic [49:0] VEC [0:NV-1] = '{
    {W,4'd4,12'h555,32'hAA}, {W,4'd4,12'h2AA,32'h55}, {W,4'd4,12'h555,32'h80},
    {W,4'd4,12'h555,32'hAA}, {W,4'd4,12'h2AA,32'h55}, {W,4'd4,12'h555,32'h10},
    {WT,4'd4,12'h000,32'd64},                       // R4 erase window
    {RD,4'd4,12'h000,32'hFFFFFFFF},                 // R4 erased
    {W,4'd2,12'h555,32'hAA}, {W,4'd2,12'h2AA,32'h55}, {W,4'd2,12'h555,32'hA0},
    {W,4'd2,12'h010,32'h12345678},
    {WT,4'd2,12'h000,32'd8},                        // R2 program window
    {RD,4'd2,12'h010,32'h12345678},                 // R2
    {W,4'd3,12'h555,32'hAA}, {W,4'd3,12'h2AA,32'h55}, {W,4'd3,12'h555,32'hA0},
    {W,4'd3,12'h010,32'hF0F0FFFF},
    {WT,4'd3,12'h000,32'd8},
    {RD,4'd3,12'h010,32'h10305678},                 // R3 AND result
    {W,4'd6,12'h555,32'hAA}, {W,4'd6,12'h2AA,32'h55}, {W,4'd6,12'h123,32'hF0},
    {W,4'd6,12'h555,32'hA0}, {W,4'd6,12'h020,32'h0},
    {WT,4'd6,12'h000,32'd0},                        // R6 no program began
    {RD,4'd6,12'h020,32'hFFFFFFFF},
    {W,4'd7,12'h555,32'hAA}, {W,4'd7,12'h2AB,32'h55}, {W,4'd7,12'h555,32'hA0},
    {W,4'd7,12'h030,32'h0},
    {WT,4'd7,12'h000,32'd0},                        // R7 broken unlock
    {RD,4'd7,12'h030,32'hFFFFFFFF},
    {W,4'd8,12'h555,32'hAA}, {W,4'd8,12'h2AA,32'h55}, {W,4'd8,12'h555,32'h90},
    {RD,4'd8,12'h000,32'h01}, {RD,4'd8,12'h001,32'h7E},      // R8 ids
    {RD,4'd8,12'h002,32'h0},  {RD,4'd8,12'h042,32'h1},       // R8 protection
    {RD,4'd8,12'h000,32'h01},
    {W,4'd9,12'h010,32'h0},
    {RD,4'd9,12'h001,32'h7E},                       // R9 still in autoselect
    {W,4'd9,12'h000,32'hF0},
    {RD,4'd9,12'h010,32'h10305678},                 // R9 array untouched
    {W,4'd10,12'h555,32'hAA}, {W,4'd10,12'h2AA,32'h55}, {W,4'd10,12'h555,32'h20},
    {W,4'd10,12'h777,32'hA0}, {W,4'd10,12'h040,32'hAAAA5555},
    {WT,4'd10,12'h000,32'd8},                       // R10 bypass program
    {W,4'd10,12'h000,32'hA0}, {W,4'd10,12'h041,32'h0000FFFF},
    {WT,4'd10,12'h000,32'd8},                       // R10 still in bypass
    {RD,4'd10,12'h040,32'hAAAA5555}, {RD,4'd10,12'h041,32'h0000FFFF},
    {W,4'd11,12'h003,32'h90}, {W,4'd11,12'h004,32'h00},
    {W,4'd11,12'h555,32'hA0}, {W,4'd11,12'h050,32'h0},
    {WT,4'd11,12'h000,32'd0},                       // R11 bypass left
    {RD,4'd11,12'h050,32'hFFFFFFFF},
    {RD,4'd1,12'h010,32'h10305678}                  // R1 array read
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    check(rdData === exp, tag, rdData, exp);
  endtask

  task automatic waitReady(input int exp, input string tag);
    int cnt = 0;
    while (!ready && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == exp, tag, cnt, exp);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ready === 1'b1, "R12 reset state", {31'b0, ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      string tag;
      op  = VEC[i][49:48];
      tag = $sformatf("R%0d vec %0d", VEC[i][47:44], i);
      case (op)
        W:  busWrite(VEC[i][43:32], VEC[i][31:0]);
        RD: busRead(VEC[i][43:32], VEC[i][31:0], tag);
        default: waitReady(int'(VEC[i][31:0]), tag);
      endcase
    end

    // R5: writes during a running program are ignored
    busWrite(12'h555, 32'hAA); busWrite(12'h2AA, 32'h55); busWrite(12'h555, 32'hA0);
    busWrite(12'h060, 32'h0);
    busWrite(12'h000, 32'hF0);
    busWrite(12'h555, 32'hAA);
    waitReady(4, "R5 window unchanged");
    busRead(12'h060, 32'h0, "R5 program completed");
    busWrite(12'h2AA, 32'h55); busWrite(12'h555, 32'hA0); busWrite(12'h061, 32'h0);
    waitReady(0, "R5 no sequence started");
    busRead(12'h061, 32'hFFFFFFFF, "R5 word untouched");

    // R12: hardware reset aborts a running program
    busWrite(12'h555, 32'hAA); busWrite(12'h2AA, 32'h55); busWrite(12'h555, 32'hA0);
    busWrite(12'h070, 32'h0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(ready === 1'b1, "R12 ready after abort", {31'b0, ready}, 32'd1);
    busRead(12'h070, 32'hFFFFFFFF, "R12 aborted word");

    // R12: hardware reset leaves autoselect
    busWrite(12'h555, 32'hAA); busWrite(12'h2AA, 32'h55); busWrite(12'h555, 32'h90);
    busRead(12'h001, 32'h7E, "R12 in autoselect");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    busRead(12'h001, 32'hFFFFFFFF, "R12 back to array read");

    finishRun();
  end

endmodule